// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a single-port synchronous memory of 18-bit words split into two 9-bit byte lanes. All commands, addresses and lane enables are captured on the rising clock edge. A read returns its word from an output register one full cycle after the command was captured. A write takes its data one cycle after its command (late write). The data first sits in a one-deep write buffer and goes into the array only when the next write is accepted. Reads check the buffer, so a read always sees the newest data, even while that data is still buffered.

The shared data pins are modelled as an input bus `wdata`, an output bus `dq_out` and a drive flag `dq_drv`. The drive flag is gated at once, without a clock, by the output-enable input and by the sleep input. The extra address bit `hi_sel` is used in one of two ways, chosen by `conv_mode`. In conventional mode it is an ordinary top address bit. In late-select mode the storage acts as two banks. For a write, `hi_sel` picks the bank in the command cycle. For a read, `hi_sel` picks the bank one cycle after the command. In both modes, bank b at address a is the same storage word as conventional index {b, a}.

Top module: `lw_sram`

## Requirements
- R1: A read command captured at edge n loads the output register at edge n+1. `dq_drv` is high from edge n+1 until edge n+2 (when output enable is high and sleep is low), and low in the cycle between edges n and n+1.
- R2: For a write command captured at edge n, the data on `wdata` is taken at edge n+1. A read command captured at edge n+1 or later returns that data.
- R3: `lane_we` bit i enables data bits [9i+8:9i] of a write. Lanes whose bit is 0 keep their previous content.
- R4: A read of the word held in the write buffer returns the buffered value for the enabled lanes and the array value for the other lanes.
- R5: With `conv_mode`=1, the word index is {hi_sel, addr}, with both sampled at the command edge, for reads and for writes.
- R6: With `conv_mode`=0, a write goes to bank `hi_sel` as sampled at its command edge. Changes to `hi_sel` in later cycles have no effect on it.
- R7: With `conv_mode`=0, a read ignores `hi_sel` at its command edge. It reads bank `hi_sel` as sampled at the following edge, which is the edge that loads the output register.
- R8: `oe`=0 forces `dq_drv` to 0 and `dq_out` to 0 in the same cycle, without waiting for a clock edge. `dq_out` is 0 whenever `dq_drv` is 0.
- R9: A command presented while `sleep`=1 is ignored: a write changes no word and a read produces no output. While `sleep`=1, `dq_drv` is 0. Stored contents are kept across sleep.
- R10: After reset, `dq_drv` and `dq_out` are 0 and the write buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_mode | input | 1 | 1: conventional addressing, 0: late bank select |
| sleep | input | 1 | Ignore commands and disable the output |
| oe | input | 1 | Asynchronous output enable |
| cmd_en | input | 1 | Command present this cycle |
| cmd_wr | input | 1 | 1: write command, 0: read command |
| addr | input | 8 | Word address inside a bank |
| hi_sel | input | 1 | Top address bit or late bank select |
| lane_we | input | 2 | Per-lane write enables of a write command |
| wdata | input | 18 | Write data, taken one cycle after the command |
| dq_out | output | 18 | Read data, 0 when not driven |
| dq_drv | output | 1 | Read data is being driven |

## Verification
Every storage word is first filled and read back in conventional mode, so any addressing fault in R5 shows up. Random mixes of reads and writes then run on four addresses in each mode. This gives back-to-back writes to the same word, reads just behind partial-lane writes, and write-after-read turns, which separate a correct buffer merge (R3, R4) from stale array reads. Directed cases test latency, the asynchronous output gating and sleep. Late-select cases drive a wrong `hi_sel` in the read command cycle and the true bank in the next cycle, so a read that uses the early sample gives a different value. A write whose `hi_sel` changes after its command cycle must still land in its first bank.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2
  } cmd_e;
endpackage

// File: rtl/lw_sram_rst_sync.sv
module lw_sram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lw_sram_store.sv
module lw_sram_store #(
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  parameter int IDX_W  = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [LANE_W*LANES-1:0] wr_data,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [LANE_W*LANES-1:0] rd_data
);
  localparam int DATA_W = LANE_W * LANES;
  localparam int WORDS  = 1 << IDX_W;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_lanes[l]) mem[wr_idx][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/lw_sram_wbuf.sv
module lw_sram_wbuf #(
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  parameter int IDX_W  = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_cap,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [LANE_W*LANES-1:0] wr_data,
  input  logic [IDX_W-1:0]        rd_idx,
  input  logic [LANE_W*LANES-1:0] arr_rdata,
  output logic [LANE_W*LANES-1:0] merged,
  output logic                    arr_we,
  output logic [IDX_W-1:0]        arr_idx,
  output logic [LANES-1:0]        arr_lanes,
  output logic [LANE_W*LANES-1:0] arr_data
);
  localparam int DATA_W = LANE_W * LANES;

  logic              bvalid_q, bvalid_d;
  logic [IDX_W-1:0]  bidx_q, bidx_d;
  logic [LANES-1:0]  blanes_q, blanes_d;
  logic [DATA_W-1:0] bdata_q, bdata_d;
  logic              hit;

  always_comb begin
    bvalid_d = bvalid_q;
    bidx_d   = bidx_q;
    blanes_d = blanes_q;
    bdata_d  = bdata_q;
    if (wr_cap) begin
      bvalid_d = 1'b1;
      bidx_d   = wr_idx;
      blanes_d = wr_lanes;
      bdata_d  = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
      bidx_q   <= '0;
      blanes_q <= '0;
      bdata_q  <= '0;
    end else begin
      bvalid_q <= bvalid_d;
      if (wr_cap) begin
        bidx_q   <= bidx_d;
        blanes_q <= blanes_d;
        bdata_q  <= bdata_d;
      end
    end
  end

  assign arr_we    = wr_cap & bvalid_q;
  assign arr_idx   = bidx_q;
  assign arr_lanes = blanes_q;
  assign arr_data  = bdata_q;

  assign hit = bvalid_q && (bidx_q == rd_idx);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = (hit && blanes_q[g]) ? bdata_q[g*LANE_W +: LANE_W]
                                                              : arr_rdata[g*LANE_W +: LANE_W];
  end

  // R2
  buf_fill_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_cap |=> bvalid_q);
  // R4
  buf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n) bvalid_q |=> bvalid_q);
endmodule

// File: rtl/lw_sram.sv
module lw_sram #(
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    conv_mode,
  input  logic                    sleep,
  input  logic                    oe,
  input  logic                    cmd_en,
  input  logic                    cmd_wr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    hi_sel,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANE_W*LANES-1:0] wdata,
  output logic [LANE_W*LANES-1:0] dq_out,
  output logic                    dq_drv
);
  import lw_sram_pkg::*;

  localparam int DATA_W = LANE_W * LANES;
  localparam int IDX_W  = ADDR_W + 1;

  logic rst_sync_n;

  lw_sram_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cmd_e              cmd_d, cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              sel_q;
  logic [LANES-1:0]  lanes_q;

  always_comb begin
    cmd_d = CMD_NOP;
    if (cmd_en && !sleep) cmd_d = cmd_wr ? CMD_WR : CMD_RD;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmd_q   <= CMD_NOP;
      addr_q  <= '0;
      sel_q   <= 1'b0;
      lanes_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      if (cmd_d != CMD_NOP) begin
        addr_q  <= addr;
        sel_q   <= hi_sel;
        lanes_q <= lane_we;
      end
    end
  end

  logic              rd_bank;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic              wr_cap, rd_load;
  logic [DATA_W-1:0] arr_rdata, merged, arr_data;
  logic              arr_we;
  logic [IDX_W-1:0]  arr_idx;
  logic [LANES-1:0]  arr_lanes;

  assign rd_bank = conv_mode ? sel_q : hi_sel;
  assign rd_idx  = {rd_bank, addr_q};
  assign wr_idx  = {sel_q, addr_q};
  assign wr_cap  = (cmd_q == CMD_WR);
  assign rd_load = (cmd_q == CMD_RD);

  lw_sram_wbuf #(.LANE_W(LANE_W), .LANES(LANES), .IDX_W(IDX_W)) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_cap    (wr_cap),
    .wr_idx    (wr_idx),
    .wr_lanes  (lanes_q),
    .wr_data   (wdata),
    .rd_idx    (rd_idx),
    .arr_rdata (arr_rdata),
    .merged    (merged),
    .arr_we    (arr_we),
    .arr_idx   (arr_idx),
    .arr_lanes (arr_lanes),
    .arr_data  (arr_data)
  );

  lw_sram_store #(.LANE_W(LANE_W), .LANES(LANES), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .we       (arr_we),
    .wr_idx   (arr_idx),
    .wr_lanes (arr_lanes),
    .wr_data  (arr_data),
    .rd_idx   (rd_idx),
    .rd_data  (arr_rdata)
  );

  logic              rvalid_q, rvalid_d;
  logic [DATA_W-1:0] dout_q;

  always_comb rvalid_d = rd_load;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rvalid_q <= 1'b0;
      dout_q   <= '0;
    end else begin
      rvalid_q <= rvalid_d;
      if (rd_load) dout_q <= merged;
    end
  end

  assign dq_drv = oe & ~sleep & rvalid_q;
  assign dq_out = dq_drv ? dout_q : '0;

  // R1
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_en && !cmd_wr && !sleep) |=> ##1 rvalid_q);
  // R2
  commit_on_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    arr_we |-> (cmd_q == CMD_WR));
  // R9
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sleep |-> !dq_drv);
  // R8
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !oe |-> (dq_out == '0));
endmodule

// File: tb/tb_lw_sram.sv
`timescale 1ns/1ps
module tb_lw_sram;
  localparam real HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n, conv_mode, sleep, oe, cmd_en, cmd_wr, hi_sel;
  logic [7:0]  addr;
  logic [1:0]  lane_we;
  logic [17:0] wdata, dq_out;
  logic        dq_drv;

  always #(HALF) clk = ~clk;

  lw_sram dut (
    .clk(clk), .rst_n(rst_n), .conv_mode(conv_mode), .sleep(sleep), .oe(oe),
    .cmd_en(cmd_en), .cmd_wr(cmd_wr), .addr(addr), .hi_sel(hi_sel),
    .lane_we(lane_we), .wdata(wdata), .dq_out(dq_out), .dq_drv(dq_drv)
  );

  typedef struct {
    logic [17:0] d;
    int          due;
    string       req;
  } item_t;

  item_t       exp_q[$];
  logic [17:0] ref_mem [512];
  int          checks = 0;
  int          failures = 0;
  int          cyc = 0;
  bit          mon_on = 1'b1;
  bit          ls_wait = 1'b0;
  bit          ls_bank, ls_push;
  int          ls_addr;
  string       ls_req;
  logic [17:0] pend_wd = '0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input logic [17:0] act, input logic [17:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic push(input logic [17:0] d, input int due, input string req);
    item_t it;
    it.d = d; it.due = due; it.req = req;
    exp_q.push_back(it);
  endtask

  // kind: 0 idle, 1 read, 2 write
  task automatic op(input int kind, input int a, input bit s, input bit late,
                    input logic [1:0] ln, input logic [17:0] d, input string req);
    bit pin;
    int idx;
    @(posedge clk); #1;
    pin = ls_wait ? ls_bank : s;
    if (ls_wait) begin
      if (ls_push) push(ref_mem[(ls_bank ? 256 : 0) + ls_addr], cyc + 1, ls_req);
      ls_wait = 1'b0;
    end
    cmd_en  = (kind != 0);
    cmd_wr  = (kind == 2);
    addr    = a[7:0];
    hi_sel  = pin;
    lane_we = ln;
    wdata   = pend_wd;
    pend_wd = d;
    idx = (pin ? 256 : 0) + a;
    if (kind == 2 && !sleep) begin
      if (ln[0]) ref_mem[idx][8:0]  = d[8:0];
      if (ln[1]) ref_mem[idx][17:9] = d[17:9];
    end
    if (kind == 1 && !sleep) begin
      if (conv_mode) begin
        if (mon_on && oe) push(ref_mem[idx], cyc + 2, req);
      end else begin
        ls_wait = 1'b1;
        ls_bank = late;
        ls_addr = a;
        ls_push = mon_on && oe;
        ls_req  = req;
      end
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) op(0, 0, 1'b0, 1'b0, 2'b00, 18'h0, "");
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        item_t it;
        it = exp_q.pop_front();
        chk(dq_drv && dq_out === it.d, it.req, dq_drv ? dq_out : 18'h3ffff, it.d);
      end else if (dq_drv) begin
        chk(1'b0, "R1", dq_out, 18'h0);
      end
    end
  end

  initial begin
    #(HALF * 2 * 60000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [17:0] v;
    rst_n = 1'b0; conv_mode = 1'b1; sleep = 1'b0; oe = 1'b1;
    cmd_en = 1'b0; cmd_wr = 1'b0; addr = '0; hi_sel = 1'b0; lane_we = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(dq_drv == 1'b0, "R10", {17'h0, dq_drv}, 18'h0);
    chk(dq_out == 18'h0, "R10", dq_out, 18'h0);

    // fill and read back every word, conventional mode (R2, R5)
    for (int i = 0; i < 512; i++)
      op(2, i % 256, (i >= 256), 1'b0, 2'b11, 18'(i * 613 + 17), "R2");
    for (int i = 0; i < 512; i++)
      op(1, i % 256, (i >= 256), 1'b0, 2'b00, 18'h0, "R5");
    drain();

    // R1 latency and R8 asynchronous output enable
    mon_on = 1'b0;
    op(1, 3, 1'b0, 1'b0, 2'b00, 18'h0, "R1");
    op(0, 0, 1'b0, 1'b0, 2'b00, 18'h0, "");
    @(negedge clk);
    chk(dq_drv == 1'b0, "R1", {17'h0, dq_drv}, 18'h0);
    @(negedge clk);
    chk(dq_drv == 1'b1 && dq_out == ref_mem[3], "R1", dq_out, ref_mem[3]);
    oe = 1'b0; #0.5;
    chk(dq_drv == 1'b0 && dq_out == 18'h0, "R8", dq_out, 18'h0);
    oe = 1'b1; #0.5;
    chk(dq_drv == 1'b1 && dq_out == ref_mem[3], "R8", dq_out, ref_mem[3]);
    @(negedge clk);
    chk(dq_drv == 1'b0, "R1", {17'h0, dq_drv}, 18'h0);

    // R9 output held off during sleep
    op(1, 3, 1'b0, 1'b0, 2'b00, 18'h0, "R9");
    op(0, 0, 1'b0, 1'b0, 2'b00, 18'h0, "");
    sleep = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(dq_drv == 1'b0 && dq_out == 18'h0, "R9", dq_out, 18'h0);
    @(posedge clk); #1;
    sleep = 1'b0;
    drain();
    mon_on = 1'b1;

    // R9 commands ignored while asleep, contents kept
    sleep = 1'b1;
    op(2, 3, 1'b0, 1'b0, 2'b11, 18'h2aaaa, "R9");
    op(1, 3, 1'b0, 1'b0, 2'b00, 18'h0, "R9");
    op(0, 0, 1'b0, 1'b0, 2'b00, 18'h0, "");
    op(0, 0, 1'b0, 1'b0, 2'b00, 18'h0, "");
    sleep = 1'b0;
    op(1, 3, 1'b0, 1'b0, 2'b00, 18'h0, "R9");
    drain();

    // R3 lanes and R4 coherency
    op(2, 9, 1'b0, 1'b0, 2'b11, 18'h12345, "R3");
    op(2, 9, 1'b0, 1'b0, 2'b01, 18'h3f0ff, "R3");
    op(1, 9, 1'b0, 1'b0, 2'b00, 18'h0, "R4");
    op(2, 9, 1'b0, 1'b0, 2'b10, 18'h0abcd, "R4");
    op(1, 9, 1'b0, 1'b0, 2'b00, 18'h0, "R4");
    op(2, 10, 1'b0, 1'b0, 2'b00, 18'h3ffff, "R3");
    op(1, 10, 1'b0, 1'b0, 2'b00, 18'h0, "R3");
    op(2, 11, 1'b0, 1'b0, 2'b11, 18'h00001, "R3");
    op(1, 9, 1'b0, 1'b0, 2'b00, 18'h0, "R3");
    drain();

    // R5 top bit separates the two halves
    op(2, 5, 1'b1, 1'b0, 2'b11, 18'h11111, "R5");
    op(2, 5, 1'b0, 1'b0, 2'b11, 18'h22222, "R5");
    op(1, 5, 1'b1, 1'b0, 2'b00, 18'h0, "R5");
    op(1, 5, 1'b0, 1'b0, 2'b00, 18'h0, "R5");
    drain();

    // random mix, conventional mode
    for (int i = 0; i < 300; i++)
      op($urandom % 3, $urandom % 4, 1'($urandom), 1'b0, 2'($urandom), 18'($urandom), "R4");
    drain();

    // late-select mode
    conv_mode = 1'b0;
    // R6: bank taken at command edge, pin changes afterwards
    op(2, 7, 1'b1, 1'b0, 2'b11, 18'h0a5a5, "R6");
    op(0, 0, 1'b0, 1'b0, 2'b00, 18'h0, "");
    op(2, 7, 1'b0, 1'b0, 2'b11, 18'h35a5a, "R6");
    op(0, 0, 1'b1, 1'b0, 2'b00, 18'h0, "");
    drain();
    // R7: decoy pin in command cycle, true bank next cycle
    op(1, 7, 1'b0, 1'b1, 2'b00, 18'h0, "R7");
    op(1, 7, 1'b1, 1'b0, 2'b00, 18'h0, "R7");
    op(0, 0, 1'b0, 1'b0, 2'b00, 18'h0, "");
    op(1, 7, 1'b0, 1'b1, 2'b00, 18'h0, "R7");
    op(2, 7, 1'b0, 1'b0, 2'b01, 18'h00000, "R7");
    op(1, 7, 1'b1, 1'b1, 2'b00, 18'h0, "R4");
    drain();
    for (int i = 0; i < 300; i++)
      op($urandom % 3, $urandom % 4, 1'($urandom), 1'($urandom), 2'($urandom), 18'($urandom), "R7");
    drain();
    conv_mode = 1'b1;
    // cross-mode storage mapping (R6)
    op(1, 7, 1'b1, 1'b0, 2'b00, 18'h0, "R6");
    op(1, 7, 1'b0, 1'b0, 2'b00, 18'h0, "R6");
    drain();

    chk(exp_q.size() == 0, "R1", 18'(exp_q.size()), 18'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule